// File: doc/BRIEF.md
# Snooping Update-Protocol Cache Controller

This controller manages a tiny direct-mapped cache with two one-word lines. It sits on a shared bus next to other copies of itself and a single main memory. Each resident line carries a Shared flag and a Dirty flag, and a separate valid bit marks empty lines. A write to a line that is not shared stays in the cache as a write-back. A write to a line that is shared goes out on the bus as a write-through, and every other holder takes the new value instead of dropping its copy.

The CPU side takes one request at a time and holds it until `cpu_done` pulses. Only read hits and writes to unshared lines finish without the bus. Every other request is turned into a sequence of bus transactions: an optional write-back of a dirty victim, a line read, and an optional write-through. The controller keeps `bus_req` raised with a fixed command until the bus finishes it with `bus_done` during `bus_gnt`.

While another cache owns the bus, the controller watches the snoop port. It raises `snp_hit` when it holds the addressed line, and supplies the data when another cache reads a line it holds dirty. It merges snooped writes into its own copy. Address bit 0 selects the set and the upper bits form the tag.

Top module: `upd_snoop_cache`

## Requirements
- R1: A synchronous reset marks every line invalid and leaves `bus_req` and `cpu_done` low, so the first access to any address after reset misses.
- R2: A read miss issues a bus read (`bus_cmd` = 01) to the requested address and returns the bus data. A later read of the same address hits, returns the cached word and causes no bus traffic.
- R3: A line loaded by a bus read becomes Shared if `bus_shared` was high when that read completed, and unshared otherwise.
- R4: A CPU write that hits an unshared line updates only the cache and sets Dirty. No bus transaction takes place and memory keeps its old value.
- R5: A CPU write that hits a Shared line issues a write-through (`bus_cmd` = 10) carrying the address and data. Afterwards the line is clean, and it stays Shared only if `bus_shared` was high at completion.
- R6: A write miss first reads the line over the bus and then applies the write, following R4 or R5 according to the Shared value just loaded.
- R7: Replacing a dirty line first issues a write-back (`bus_cmd` = 11) of the old tag and data. The bus read for the new address follows directly after it.
- R8: While `snp_valid` is high, `snp_hit` is high exactly when the snooped address is resident. The completing master therefore sees `bus_shared` high if and only if another cache holds the line.
- R9: A snooped read of a line held Dirty raises `snp_supply` with the line data on `snp_sdata`. When the read completes, the line becomes Shared and clean.
- R10: A snooped write-through or write-back to a resident line replaces the local data, keeps the line valid and Shared, and clears Dirty.
- R11: `cpu_done` is a single-cycle pulse for each request. It comes the cycle after acceptance for a request that needs no bus transaction, otherwise the cycle after the final `bus_done`. A read returns its word on `cpu_rdata` with the pulse.
- R12: Once raised, `bus_req` stays high with `bus_cmd`, `bus_addr` and `bus_wdata` unchanged until a cycle with both `bus_gnt` and `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | CPU request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address; bit 0 selects the set |
| cpu_wdata | input | DW | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read data, valid with `cpu_done` |
| bus_req | output | 1 | Request for the shared bus |
| bus_cmd | output | 2 | 01 read, 10 write-through, 11 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Data for write-through or write-back |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_done | input | 1 | Transaction completes this cycle |
| bus_rdata | input | DW | Data returned for a bus read |
| bus_shared | input | 1 | Wired-OR SHARED line, sampled at completion |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_done | input | 1 | That transaction completes this cycle |
| snp_cmd | input | 2 | Command of the snooped transaction |
| snp_addr | input | AW | Address of the snooped transaction |
| snp_wdata | input | DW | Write data of the snooped transaction |
| snp_hit | output | 1 | This cache's contribution to SHARED |
| snp_supply | output | 1 | This cache supplies read data |
| snp_sdata | output | DW | Supplied line data |

## Verification
A request that needs no bus transaction produces `cpu_done` one cycle after the edge that accepts it. The bench's bus model completes each transaction two cycles after it is raised, so a request with n transactions finishes 1 + 2n cycles after it is presented. The bench derives n from its own line-state model and checks the measured latency against 1 + 2n, sampling on falling edges. It then checks that the pulse has dropped one cycle later. It also logs each transaction's command, address and SHARED value in the cycle of `bus_done`. Once `cpu_done` is seen, it compares that log, the returned word and every clean memory word with the model.

// File: rtl/upd_snoop_cache.sv
`timescale 1ns/1ps
module upd_snoop_cache #(
  parameter int AW = 2,
  parameter int DW = 8,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic          bus_done,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_shared,
  input  logic          snp_valid,
  input  logic          snp_done,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_wdata,
  output logic          snp_hit,
  output logic          snp_supply,
  output logic [DW-1:0] snp_sdata
);
  localparam int NS = 1 << IW;
  localparam int TW = AW - IW;
  localparam logic [1:0] C_RD = 2'd1;
  localparam logic [1:0] C_WT = 2'd2;
  localparam logic [1:0] C_WB = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_RD, S_WT} st_t;
  st_t st;

  logic [NS-1:0] vld, shr, drt;
  logic [TW-1:0] tag [NS];
  logic [DW-1:0] dat [NS];

  logic [IW-1:0] cset, sset;
  logic [TW-1:0] ctag, stag;
  logic          hit, xfer, start;

  assign cset  = cpu_addr[IW-1:0];
  assign ctag  = cpu_addr[AW-1:IW];
  assign sset  = snp_addr[IW-1:0];
  assign stag  = snp_addr[AW-1:IW];
  assign hit   = vld[cset] && (tag[cset] == ctag);
  assign xfer  = bus_gnt && bus_done;
  assign start = cpu_req && !cpu_done && !snp_valid;

  assign bus_req   = (st != S_IDLE);
  assign bus_addr  = (st == S_WB) ? {tag[cset], cset} : cpu_addr;
  assign bus_wdata = (st == S_WB) ? dat[cset] : cpu_wdata;

  always_comb begin
    case (st)
      S_WB:    bus_cmd = C_WB;
      S_RD:    bus_cmd = C_RD;
      S_WT:    bus_cmd = C_WT;
      default: bus_cmd = 2'd0;
    endcase
  end

  assign snp_hit    = snp_valid && vld[sset] && (tag[sset] == stag);
  assign snp_supply = snp_hit && (snp_cmd == C_RD) && drt[sset];
  assign snp_sdata  = dat[sset];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      vld       <= '0;
      shr       <= '0;
      drt       <= '0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      for (int i = 0; i < NS; i++) begin
        tag[i] <= '0;
        dat[i] <= '0;
      end
    end else begin
      cpu_done <= 1'b0;
      if (snp_done && snp_hit) begin
        shr[sset] <= 1'b1;
        drt[sset] <= 1'b0;
        if (snp_cmd != C_RD) dat[sset] <= snp_wdata;
      end
      case (st)
        S_IDLE: begin
          if (start) begin
            if (hit && !cpu_we) begin
              cpu_rdata <= dat[cset];
              cpu_done  <= 1'b1;
            end else if (hit && shr[cset]) begin
              st <= S_WT;
            end else if (hit) begin
              dat[cset] <= cpu_wdata;
              drt[cset] <= 1'b1;
              cpu_done  <= 1'b1;
            end else if (vld[cset] && drt[cset]) begin
              st <= S_WB;
            end else begin
              st <= S_RD;
            end
          end
        end
        S_WB: begin
          if (xfer) begin
            drt[cset] <= 1'b0;
            st        <= S_RD;
          end
        end
        S_RD: begin
          if (xfer) begin
            vld[cset] <= 1'b1;
            tag[cset] <= ctag;
            shr[cset] <= bus_shared;
            drt[cset] <= cpu_we && !bus_shared;
            if (!cpu_we) begin
              dat[cset] <= bus_rdata;
              cpu_rdata <= bus_rdata;
              cpu_done  <= 1'b1;
              st        <= S_IDLE;
            end else if (bus_shared) begin
              dat[cset] <= bus_rdata;
              st        <= S_WT;
            end else begin
              dat[cset] <= cpu_wdata;
              cpu_done  <= 1'b1;
              st        <= S_IDLE;
            end
          end
        end
        default: begin
          if (xfer) begin
            dat[cset] <= cpu_wdata;
            shr[cset] <= bus_shared;
            drt[cset] <= 1'b0;
            cpu_done  <= 1'b1;
            st        <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/upd_snoop_cache_chk.sv
`timescale 1ns/1ps
module upd_snoop_cache_chk #(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_req,
  input logic          cpu_done,
  input logic          bus_req,
  input logic [1:0]    bus_cmd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_gnt,
  input logic          bus_done,
  input logic          snp_valid,
  input logic [1:0]    snp_cmd,
  input logic          snp_hit,
  input logic          snp_supply
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !bus_req && !cpu_done);

  a_r12_request_held: assert property (@(posedge clk) disable iff (rst)
    bus_req && !(bus_gnt && bus_done) |=>
      bus_req && $stable(bus_cmd) && $stable(bus_addr) && $stable(bus_wdata));

  a_r12_command_legal: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> bus_cmd != 2'd0);

  a_r7_writeback_then_read: assert property (@(posedge clk) disable iff (rst)
    bus_gnt && bus_done && bus_cmd == 2'd3 |=> bus_req && bus_cmd == 2'd1);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  a_r11_done_needs_request: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> $past(cpu_req) && !bus_req);

  a_r8_hit_only_when_snooping: assert property (@(posedge clk) disable iff (rst)
    snp_hit |-> snp_valid);

  a_r9_supply_on_read_hit: assert property (@(posedge clk) disable iff (rst)
    snp_supply |-> snp_hit && snp_cmd == 2'd1);
endmodule

bind upd_snoop_cache upd_snoop_cache_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/upd_snoop_cache_tb_top.sv
`timescale 1ns/1ps
module upd_snoop_cache_tb_top;
  localparam int AW = 2;
  localparam int DW = 8;
  localparam int NC = 3;
  localparam int NA = 4;
  localparam int LG = 1024;
  localparam logic [1:0] C_RD = 2'd1;
  localparam logic [1:0] C_WT = 2'd2;
  localparam logic [1:0] C_WB = 2'd3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst;

  logic [NC-1:0] c_req, c_we, b_gnt, b_done, b_sh, s_valid, s_done;
  logic [AW-1:0] c_addr [NC];
  logic [DW-1:0] c_wdata [NC];
  wire  [NC-1:0] c_done, b_req, s_hit, s_sup;
  wire  [DW-1:0] c_rdata [NC];
  wire  [AW-1:0] b_addr [NC];
  wire  [DW-1:0] b_wdata [NC];
  wire  [DW-1:0] s_sdata [NC];
  wire  [1:0]    b_cmd [NC];

  logic          busy, done_r, sup_any;
  logic [1:0]    own, bcmd;
  logic [AW-1:0] baddr;
  logic [DW-1:0] bdata, sup_d, rd_data;
  logic [DW-1:0] mem [NA];
  logic [1:0]    lg_c [LG];
  logic [AW-1:0] lg_a [LG];
  logic          lg_s [LG];
  int            lg_n;

  for (genvar g = 0; g < NC; g++) begin : g_cache
    upd_snoop_cache #(.AW(AW), .DW(DW), .IW(1)) dut_i (
      .clk(clk), .rst(rst),
      .cpu_req(c_req[g]), .cpu_we(c_we[g]), .cpu_addr(c_addr[g]), .cpu_wdata(c_wdata[g]),
      .cpu_done(c_done[g]), .cpu_rdata(c_rdata[g]),
      .bus_req(b_req[g]), .bus_cmd(b_cmd[g]), .bus_addr(b_addr[g]), .bus_wdata(b_wdata[g]),
      .bus_gnt(b_gnt[g]), .bus_done(b_done[g]), .bus_rdata(rd_data), .bus_shared(b_sh[g]),
      .snp_valid(s_valid[g]), .snp_done(s_done[g]), .snp_cmd(bcmd), .snp_addr(baddr),
      .snp_wdata(bdata), .snp_hit(s_hit[g]), .snp_supply(s_sup[g]), .snp_sdata(s_sdata[g]));
  end

  always_comb begin
    busy = 1'b0;
    own  = 2'd0;
    for (int i = NC - 1; i >= 0; i--) begin
      if (b_req[i]) begin
        busy = 1'b1;
        own  = 2'(i);
      end
    end
    bcmd  = b_cmd[own];
    baddr = b_addr[own];
    bdata = b_wdata[own];
    for (int i = 0; i < NC; i++) begin
      b_gnt[i]   = busy && (own == 2'(i));
      s_valid[i] = busy && (own != 2'(i));
      s_done[i]  = busy && (own != 2'(i)) && done_r;
      b_done[i]  = busy && (own == 2'(i)) && done_r;
    end
  end

  always_comb begin
    sup_any = 1'b0;
    sup_d   = '0;
    for (int i = 0; i < NC; i++) begin
      if (s_sup[i]) begin
        sup_any = 1'b1;
        sup_d   = s_sdata[i];
      end
    end
    rd_data = sup_any ? sup_d : mem[baddr];
    b_sh    = {NC{|s_hit}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_r <= 1'b0;
      lg_n   <= 0;
      for (int i = 0; i < NA; i++) mem[i] <= DW'(16 + i);
    end else begin
      done_r <= busy && !done_r;
      if (busy && done_r) begin
        if (bcmd == C_WT || bcmd == C_WB) mem[baddr] <= bdata;
        else if (sup_any) mem[baddr] <= sup_d;
        if (lg_n < LG) begin
          lg_c[lg_n] <= bcmd;
          lg_a[lg_n] <= baddr;
          lg_s[lg_n] <= |s_hit;
        end
        lg_n <= lg_n + 1;
      end
    end
  end

  int nt = 0;
  int nf = 0;
  int wcnt = 0;
  int mv [NC][2];
  int ms [NC][2];
  int md [NC][2];
  int mt [NC][2];
  logic [DW-1:0] gold [NA];
  int ex_n;
  logic [1:0] ex_c [4];
  int ex_a [4];
  int ex_s [4];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nt++;
    if (!ok) begin
      nf++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] cmd, input int a, input int sh);
    ex_c[ex_n] = cmd;
    ex_a[ex_n] = a;
    ex_s[ex_n] = sh;
    ex_n++;
  endtask

  task automatic op(input int c, input bit we, input int a, input string tag);
    int s, t, others, lat, st0, dirty;
    logic [DW-1:0] wv, rv;
    s = a % 2;
    t = a / 2;
    ex_n = 0;
    others = 0;
    for (int j = 0; j < NC; j++)
      if (j != c && mv[j][s] != 0 && mt[j][s] == t) others = 1;
    wv = '0;
    if (we) begin
      wcnt++;
      wv = DW'(wcnt);
    end
    if (mv[c][s] != 0 && mt[c][s] == t) begin
      if (we && ms[c][s] != 0) begin
        push(C_WT, a, others);
        ms[c][s] = others;
        md[c][s] = 0;
      end else if (we) begin
        md[c][s] = 1;
      end
    end else begin
      if (mv[c][s] != 0 && md[c][s] != 0) push(C_WB, mt[c][s] * 2 + s, 0);
      push(C_RD, a, others);
      mv[c][s] = 1;
      mt[c][s] = t;
      ms[c][s] = others;
      md[c][s] = 0;
      if (we && others != 0) push(C_WT, a, others);
      else if (we) md[c][s] = 1;
    end
    if (ex_n > 0)
      for (int j = 0; j < NC; j++)
        if (j != c && mv[j][s] != 0 && mt[j][s] == t) begin
          ms[j][s] = 1;
          md[j][s] = 0;
        end
    if (we) gold[a] = wv;
    st0 = lg_n;
    @(negedge clk);
    c_we[c]    = we;
    c_addr[c]  = AW'(a);
    c_wdata[c] = wv;
    c_req[c]   = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (c_done[c] !== 1'b1 && lat < 200);
    rv = c_rdata[c];
    c_req[c] = 1'b0;
    chk(lat == 1 + 2 * ex_n, {tag, " R11 completion latency"}, lat, 1 + 2 * ex_n);
    @(negedge clk);
    chk(c_done[c] == 1'b0, {tag, " R11 single done pulse"}, int'(c_done[c]), 0);
    chk(lg_n - st0 == ex_n, {tag, " bus transaction count"}, lg_n - st0, ex_n);
    for (int k = 0; k < ex_n; k++) begin
      if (st0 + k < LG) begin
        chk(lg_c[st0 + k] == ex_c[k], {tag, " R12 bus command"}, int'(lg_c[st0 + k]), int'(ex_c[k]));
        chk(int'(lg_a[st0 + k]) == ex_a[k], {tag, " bus address"}, int'(lg_a[st0 + k]), ex_a[k]);
        chk(int'(lg_s[st0 + k]) == ex_s[k], {tag, " R8 SHARED at completion"}, int'(lg_s[st0 + k]), ex_s[k]);
      end
    end
    if (!we) chk(rv == gold[a], {tag, " read data"}, int'(rv), int'(gold[a]));
    for (int x = 0; x < NA; x++) begin
      dirty = 0;
      for (int j = 0; j < NC; j++)
        if (mv[j][x % 2] != 0 && mt[j][x % 2] == x / 2 && md[j][x % 2] != 0) dirty = 1;
      if (dirty == 0) chk(mem[x] == gold[x], {tag, " clean memory word"}, int'(mem[x]), int'(gold[x]));
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    nt++;
    nf++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

  initial begin : main
    logic [31:0] sd;
    c_req = '0;
    c_we  = '0;
    for (int i = 0; i < NC; i++) begin
      c_addr[i]  = '0;
      c_wdata[i] = '0;
      for (int k = 0; k < 2; k++) begin
        mv[i][k] = 0;
        ms[i][k] = 0;
        md[i][k] = 0;
        mt[i][k] = 0;
      end
    end
    for (int i = 0; i < NA; i++) gold[i] = DW'(16 + i);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(c_done == '0 && b_req == '0, "R1 outputs idle after reset", int'(c_done | b_req), 0);

    op(0, 0, 0, "R1 R2 R3 first read misses");
    op(0, 0, 0, "R2 read hit");
    op(0, 1, 0, "R3 R4 local write");
    chk(mem[0] == 8'h10, "R4 memory left stale", int'(mem[0]), 16);
    op(1, 0, 0, "R9 dirty line supplied");
    chk(mem[0] == gold[0], "R9 memory refreshed by supply", int'(mem[0]), int'(gold[0]));
    op(0, 1, 0, "R5 write-through");
    op(1, 0, 0, "R10 snooped update");
    op(2, 1, 2, "R6 write miss unshared");
    op(1, 1, 1, "R6 write miss");
    op(2, 0, 0, "R7 dirty victim");
    chk(mem[2] == gold[2], "R7 victim written back", int'(mem[2]), int'(gold[2]));
    op(2, 1, 0, "R5 R10 shared write");
    op(0, 0, 0, "R10 update seen");

    for (int rep = 0; rep < 2; rep++)
      for (int c = 0; c < NC; c++)
        for (int a = 0; a < NA; a++)
          for (int w = 0; w < 2; w++)
            op(c, w[0], a, "R2 R3 R5 R6 R7 R8 R12 sweep");

    sd = 32'h1357_2468;
    for (int k = 0; k < 200; k++) begin
      sd = sd * 32'd1103515245 + 32'd12345;
      op(int'(sd[21:20]) % NC, sd[17], int'(sd[25:24]), "R4 R6 R7 R9 R10 mixed");
    end

    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end
endmodule